// File: doc/BRIEF.md
# Lock-Gated Two-Ratio Frequency Modulation Controller

This block chooses which of two operating frequencies a clock synthesis loop aims for. It drives one select line to the reference divider and one to the feedback divider. While the loop is not locked, both selects stay at the upper-frequency ratio. Once lock is reported, the controller switches the target back and forth between the upper and lower ratios. A down-counter sets how long the loop dwells at each ratio.

A normal-mode enable turns modulation on. When the enable is low, the controller parks in a hold state at the upper frequency and the dwell counter stays cleared. If lock drops at any point during modulation, the controller goes back to waiting and the upper ratio is restored. The dwell length is programmable. It is read once at the start of each dwell period, so a change made part-way through a period only affects the next period.

Top module: `fm_ratio_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0 (hold), and n_sel_o and m_sel_o are 0. A select value of 0 means the upper-frequency ratio and 1 means the lower-frequency ratio.
- R2: If norm_en_i is low at a clock edge, state_o is 0 and both selects are 0 after that edge, whatever the state was before. The dwell counter is cleared, so a later period always starts from a freshly sampled dwell value.
- R3: If norm_en_i is high and lock_i is low at an edge, state_o is 1 (waiting for lock) and both selects are 0 after that edge. The controller stays in that condition for as long as lock stays low.
- R4: In state 1, an edge with norm_en_i and lock_i both high moves the controller to state 2 (modulating, upper ratio) with both selects at 0.
- R5: State 2 lasts D+1 cycles, where D is the value of dwell_i sampled on the edge that entered state 2. It is then followed by state 3 (modulating, lower ratio) with both selects at 1.
- R6: State 3 lasts D+1 cycles, where D is the value of dwell_i sampled on the edge that entered state 3. It is then followed by state 2. This alternation continues for as long as lock and the enable stay high.
- R7: Changing dwell_i during a dwell period has no effect on the length of that period.
- R8: If lock_i is low at an edge while the controller is in state 2 or 3, with the enable high, the controller moves to state 1 and both selects return to 0.
- R9: n_sel_o and m_sel_o are always equal and always change on the same edge. They are 1 exactly when state_o is 3.
- R10: With a dwell value of 0, the controller switches between states 2 and 3 on every clock edge while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Loop lock indication |
| norm_en_i | input | 1 | Normal-mode enable; low parks the controller at the upper ratio |
| dwell_i | input | DWELL_W | Dwell length minus one, read at the start of each period |
| n_sel_o | output | 1 | Feedback divider ratio select (0 upper, 1 lower) |
| m_sel_o | output | 1 | Reference divider ratio select (0 upper, 1 lower) |
| state_o | output | 2 | Current state: 0 hold, 1 wait lock, 2 modulating upper, 3 modulating lower |

## Verification
state_o is the state register itself, so a wrong next-state decision shows up at the port on the edge right after it happens. The selects then show the same error because they are decoded from that state. A wrong dwell count cannot be seen at once. It appears only at the end of the period, as a switch that comes one or more cycles early or late. For that reason the bench counts the cycles in every period for a range of dwell values, including dwell values that change in the middle of a period. A select register that drifts out of step with its partner is caught on the very edge where it diverges.

// File: rtl/fm_ctrl_pkg.sv
package fm_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } fm_state_e;

  localparam int unsigned NUM_SEL = 2;
endpackage

// File: rtl/fm_dwell_cnt.sv
module fm_dwell_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)              cnt_d = '0;
    else if (load_i)          cnt_d = load_val_i;
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fm_sel_regs.sv
module fm_sel_regs #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           low_d_i,
  output logic [NUM-1:0] sel_o
);
  // one flop per divider, all loaded from the same next-state decode
  for (genvar g = 0; g < NUM; g++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_o[g] <= 1'b0;
      else         sel_o[g] <= low_d_i;
    end
  end
endmodule

// File: rtl/fm_ratio_ctrl.sv
module fm_ratio_ctrl
  import fm_ctrl_pkg::*;
#(
  parameter int unsigned DWELL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_i,
  input  logic               norm_en_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               n_sel_o,
  output logic               m_sel_o,
  output logic [1:0]         state_o
);
  fm_state_e state_q, state_d;
  logic load, clear, expired;
  logic [NUM_SEL-1:0] sel;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    if (!norm_en_i) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: state_d = ST_WAIT;
        ST_WAIT: if (lock_i) begin
          state_d = ST_HIGH;
          load    = 1'b1;
        end
        ST_HIGH: begin
          if (!lock_i) state_d = ST_WAIT;
          else if (expired) begin
            state_d = ST_LOW;
            load    = 1'b1;
          end
        end
        ST_LOW: begin
          if (!lock_i) state_d = ST_WAIT;
          else if (expired) begin
            state_d = ST_HIGH;
            load    = 1'b1;
          end
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  // counter only runs while modulating
  assign clear = !(state_d == ST_HIGH || state_d == ST_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  fm_dwell_cnt #(.W(DWELL_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .load_i     (load),
    .load_val_i (dwell_i),
    .expired_o  (expired)
  );

  fm_sel_regs #(.NUM(NUM_SEL)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .low_d_i (state_d == ST_LOW),
    .sel_o   (sel)
  );

  assign n_sel_o = sel[0];
  assign m_sel_o = sel[1];
  assign state_o = state_q;
endmodule

// File: rtl/fm_ratio_ctrl_chk.sv
module fm_ratio_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lock_i,
  input logic       norm_en_i,
  input logic       n_sel_o,
  input logic       m_sel_o,
  input logic [1:0] state_o
);
  // R9
  sel_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_sel_o == m_sel_o);

  // R9
  sel_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_sel_o == (state_o == 2'd3));

  // R2
  norm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !norm_en_i |=> (state_o == 2'd0 && !n_sel_o));

  // R3
  no_lock_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_en_i && !lock_i) |=> (state_o == 2'd1 && !n_sel_o));

  // R4
  lock_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && norm_en_i && lock_i) |=> state_o == 2'd2);

  // R6
  mod_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1] && norm_en_i && lock_i) |=> state_o[1]);
endmodule

bind fm_ratio_ctrl fm_ratio_ctrl_chk u_chk (.*);

// File: tb/fm_ratio_ctrl_tb.sv
module fm_ratio_ctrl_tb;
  localparam int unsigned DW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, lock_i = 1'b0, norm_en_i = 1'b0;
  logic [DW-1:0] dwell_i = '0;
  logic n_sel_o, m_sel_o;
  logic [1:0] state_o;
  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  fm_ratio_ctrl #(.DWELL_W(DW)) u_dut (.*);

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input logic [1:0] exp, input string req);
    logic es;
    es = (exp == 2'd3);
    n_run++;
    if (state_o !== exp || n_sel_o !== es || m_sel_o !== es) begin
      n_fail++;
      $display("FAIL %s: state=%0d n=%0b m=%0b expected state=%0d sel=%0b",
               req, state_o, n_sel_o, m_sel_o, exp, es);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1
    #5;
    chk(2'd0, "R1");
    @(negedge clk_i);
    chk(2'd0, "R1");
    rst_ni = 1'b1;
    // R2: no enable, lock high
    lock_i = 1'b1;
    for (int i = 0; i < 3; i++) begin tick(); chk(2'd0, "R2"); end
    // R3
    lock_i = 1'b0; norm_en_i = 1'b1;
    for (int i = 0; i < 5; i++) begin tick(); chk(2'd1, "R3"); end

    // sweep of dwell values: R4 R5 R6 R10
    for (int d = 0; d <= 5; d++) begin
      norm_en_i = 1'b0; lock_i = 1'b0; dwell_i = DW'(d);
      tick(); chk(2'd0, "R2");
      norm_en_i = 1'b1;
      tick(); chk(2'd1, "R3");
      lock_i = 1'b1;
      tick(); chk(2'd2, "R4");
      for (int k = 0; k < 4 * (d + 1); k++) begin
        chk(((k / (d + 1)) % 2) != 0 ? 2'd3 : 2'd2, d == 0 ? "R10" : "R5 R6");
        tick();
      end
    end

    // R7: dwell changed mid-period
    norm_en_i = 1'b0; lock_i = 1'b0; dwell_i = 8'd2;
    tick(); norm_en_i = 1'b1;
    tick(); lock_i = 1'b1;
    tick(); chk(2'd2, "R7");
    dwell_i = 8'd5;
    tick(); chk(2'd2, "R7");
    tick(); chk(2'd2, "R7");
    tick(); chk(2'd3, "R7");
    dwell_i = 8'd1;
    for (int i = 0; i < 5; i++) begin tick(); chk(2'd3, "R7"); end
    tick(); chk(2'd2, "R7");
    tick(); chk(2'd2, "R7");
    tick(); chk(2'd3, "R7");

    // R8: lock lost in lower state
    lock_i = 1'b0;
    tick(); chk(2'd1, "R8");
    lock_i = 1'b1; dwell_i = 8'd3;
    for (int k = 0; k < 8; k++) begin
      tick(); chk(k < 4 ? 2'd2 : 2'd3, "R8");
    end
    lock_i = 1'b0;
    tick(); chk(2'd1, "R8");

    // R2: enable dropped mid-period, counter cleared, fresh dwell after
    lock_i = 1'b1; dwell_i = 8'd6;
    tick(); chk(2'd2, "R2");
    tick(); chk(2'd2, "R2");
    norm_en_i = 1'b0;
    tick(); chk(2'd0, "R2");
    norm_en_i = 1'b1; dwell_i = 8'd1;
    tick(); chk(2'd1, "R2");
    tick(); chk(2'd2, "R2");
    tick(); chk(2'd2, "R2");
    tick(); chk(2'd3, "R2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule